// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Micro-TLB

This block is a small translation cache for one fixed page size, placed in front of a slower translation path. A lookup presents a virtual page number, the current address-space identifier (ASID), the current security state and an access kind. In the same cycle the block returns a hit flag, the physical frame number and a permission-abort flag. All entries are compared in parallel, so the cache is fully associative.

On a miss the slower path supplies a refill. The entry written is the lowest-index free slot if one exists. When every slot is full, the victim comes from a round-robin pointer or from a free-running pseudo-random generator, chosen by a control input. Software-driven maintenance can discard every entry at once, or only the non-global entries that belong to one ASID.

Top module: `utlb_top`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid, so every lookup misses with `lk_hit`=0, `lk_pfn`=0 and `lk_abort`=0.
- R2: A lookup is combinational and is answered in the cycle it is presented. An entry written by a refill at a rising edge is visible to lookups from the following cycle on.
- R3: A non-global entry hits only if it is valid, its page number equals `lk_vpn`, its ASID equals `lk_asid` and its non-secure bit equals `lk_ns`.
- R4: A global entry ignores `lk_asid` but still needs page number and `lk_ns` to match. On a miss `lk_pfn` reads zero.
- R5: The entry permission field has bit 0 = read allowed, bit 1 = write allowed and bit 2 = execute allowed. `lk_acc` encodes 00 as read, 01 as write, 10 as execute and 11 as reserved, and reserved is always denied. `lk_abort` is 1 exactly when a hit occurs and the access is not allowed. It is never 1 without a hit.
- R6: When any entry is invalid, a refill writes the lowest-index invalid entry, whatever the policy.
- R7: With `pol_rand`=0 and all entries valid, a refill replaces the entry named by a pointer. The pointer is 0 after reset and advances by one, modulo the entry count, after every refill under either policy.
- R8: With `pol_rand`=1 and all entries valid, a refill replaces exactly one entry, picked by a free-running 5-bit LFSR. Every other entry still hits afterwards.
- R9: `inv_all` invalidates every entry at the next edge. A refill in the same cycle is still written and survives.
- R10: `inv_asid_en` invalidates every valid non-global entry whose ASID equals `inv_asid`. Global entries and entries of other ASIDs are left untouched.
- R11: When several entries match, the lowest index supplies `lk_pfn` and the permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_ns | input | 1 | Current security state (1 = non-secure) |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Physical frame number (zero on miss) |
| lk_abort | output | 1 | Permission abort, only with hit |
| rf_en | input | 1 | Refill write strobe |
| rf_vpn | input | VPN_W | Refill page number |
| rf_asid | input | ASID_W | Refill ASID |
| rf_ns | input | 1 | Refill non-secure bit |
| rf_global | input | 1 | Refill global flag |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | 3 | Refill permissions {exec, write, read} |
| pol_rand | input | 1 | Victim policy: 0 round-robin, 1 pseudo-random |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_en | input | 1 | Invalidate non-global entries of one ASID |
| inv_asid | input | ASID_W | ASID to invalidate |

## Verification
The bench keeps a slot-by-slot model and sweeps every stored page under all four access kinds. It also probes each page with a flipped ASID and a flipped security bit. A tag compare that ignored the ASID, or applied the global flag to the security bit, would hit where a miss is expected. A permission decode with swapped bits would abort on the wrong access kinds.

For replacement, the bench fills the cache and then checks that the round-robin evictions take slots 0 and 1 in turn. It checks that a random refill removes exactly one page and that a refill after an ASID flush reuses a freed slot rather than evicting a live one. A victim chooser that ignored free slots, or a pointer that advanced only on some refills, would remove a page the model still expects to hit.

Duplicate pages and a refill in the same cycle as a full flush catch, respectively, a priority chain inverted to the highest index and a flush that overrides the write.

// File: rtl/utlb_pkg.sv
`timescale 1ns/1ps
// utlb_pkg: shared encodings for the micro-TLB.
// Assumes: victim generator widths between 2 and 8 bits.
package utlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_t;

    localparam int PERM_W     = 3;
    localparam int PERM_READ  = 0;
    localparam int PERM_WRITE = 1;
    localparam int PERM_EXEC  = 2;

    // Galois feedback masks giving a maximal-length sequence per width.
    function automatic logic [7:0] lfsr_mask(input int width);
        case (width)
            2:       return 8'b0000_0011;
            3:       return 8'b0000_0110;
            4:       return 8'b0000_1100;
            5:       return 8'b0001_0100;
            6:       return 8'b0011_0000;
            7:       return 8'b0110_0000;
            default: return 8'b1011_1000;
        endcase
    endfunction

endpackage

// File: rtl/utlb_tag_array.sv
`timescale 1ns/1ps
// utlb_tag_array: holds N translation entries and compares all of them
// with the lookup tag in parallel. Writes land at the rising edge.
// Assumes: a write to a slot overrides an invalidation of that slot in
// the same cycle.
module utlb_tag_array
    import utlb_pkg::*;
#(
    parameter int N      = 32,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [ASID_W-1:0]    lk_asid,
    input  logic                 lk_ns,
    output logic [N-1:0]         match_vec,
    output logic [N-1:0]         valid_vec,
    output logic [N*PFN_W-1:0]   pfn_flat,
    output logic [N*PERM_W-1:0]  perm_flat,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [VPN_W-1:0]     wr_vpn,
    input  logic [ASID_W-1:0]    wr_asid,
    input  logic                 wr_ns,
    input  logic                 wr_glob,
    input  logic [PFN_W-1:0]     wr_pfn,
    input  logic [PERM_W-1:0]    wr_perm,
    input  logic                 inv_all,
    input  logic                 inv_asid_en,
    input  logic [ASID_W-1:0]    inv_asid
);

    localparam int IDX_W = $clog2(N);

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic              valid_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic              ns_q;
        logic              glob_q;
        logic [PFN_W-1:0]  pfn_q;
        logic [PERM_W-1:0] perm_q;
        logic              sel_wr;
        logic              kill;

        assign sel_wr = wr_en && (wr_idx == IDX_W'(g));
        assign kill   = inv_all || (inv_asid_en && !glob_q && (asid_q == inv_asid));

        // Entry storage: write wins over invalidation, else drop on flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                vpn_q   <= '0;
                asid_q  <= '0;
                ns_q    <= 1'b0;
                glob_q  <= 1'b0;
                pfn_q   <= '0;
                perm_q  <= '0;
            end else if (sel_wr) begin
                valid_q <= 1'b1;
                vpn_q   <= wr_vpn;
                asid_q  <= wr_asid;
                ns_q    <= wr_ns;
                glob_q  <= wr_glob;
                pfn_q   <= wr_pfn;
                perm_q  <= wr_perm;
            end else if (kill) begin
                valid_q <= 1'b0;
            end
        end

        // Tag compare: global entries skip the ASID field only.
        assign match_vec[g] = valid_q && (vpn_q == lk_vpn) && (ns_q == lk_ns)
                              && (glob_q || (asid_q == lk_asid));
        assign valid_vec[g] = valid_q;
        assign pfn_flat[g*PFN_W +: PFN_W]    = pfn_q;
        assign perm_flat[g*PERM_W +: PERM_W] = perm_q;
    end

endmodule

// File: rtl/utlb_hit_select.sv
`timescale 1ns/1ps
// utlb_hit_select: reduces the match vector to one hit and picks the
// lowest-index matching entry's frame number and permissions.
// Assumes: outputs are zero when nothing matches.
module utlb_hit_select
    import utlb_pkg::*;
#(
    parameter int N     = 32,
    parameter int PFN_W = 20
) (
    input  logic [N-1:0]        match_vec,
    input  logic [N*PFN_W-1:0]  pfn_flat,
    input  logic [N*PERM_W-1:0] perm_flat,
    output logic                hit,
    output logic [PFN_W-1:0]    sel_pfn,
    output logic [PERM_W-1:0]   sel_perm
);

    // Priority pick: scanning downward lets the lowest index land last.
    always_comb begin
        hit      = 1'b0;
        sel_pfn  = '0;
        sel_perm = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit      = 1'b1;
                sel_pfn  = pfn_flat[i*PFN_W +: PFN_W];
                sel_perm = perm_flat[i*PERM_W +: PERM_W];
            end
        end
    end

endmodule

// File: rtl/utlb_perm_check.sv
`timescale 1ns/1ps
// utlb_perm_check: decides whether an access kind is allowed by a
// permission field. Assumes: the reserved access kind is never allowed.
module utlb_perm_check
    import utlb_pkg::*;
(
    input  logic [1:0]        acc,
    input  logic [PERM_W-1:0] perm,
    output logic              deny
);

    // Permission decode per access kind.
    always_comb begin
        case (acc_t'(acc))
            ACC_READ:  deny = !perm[PERM_READ];
            ACC_WRITE: deny = !perm[PERM_WRITE];
            ACC_EXEC:  deny = !perm[PERM_EXEC];
            default:   deny = 1'b1;
        endcase
    end

endmodule

// File: rtl/utlb_victim.sv
`timescale 1ns/1ps
// utlb_victim: chooses the slot a refill writes. A free slot (lowest
// index) is preferred; otherwise a round-robin pointer or a free-running
// LFSR picks it. Assumes: N is a power of two between 4 and 256.
module utlb_victim
    import utlb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid_vec,
    input  logic                 rf_en,
    input  logic                 pol_rand,
    output logic [$clog2(N)-1:0] victim_idx
);

    localparam int             IDX_W = $clog2(N);
    localparam logic [IDX_W-1:0] MASK = IDX_W'(lfsr_mask(IDX_W));

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] lfsr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Round-robin pointer: steps once per refill, whatever the policy.
    always_ff @(posedge clk) begin
        if (!rst_n)     rr_q <= '0;
        else if (rf_en) rr_q <= rr_q + 1'b1;
    end

    // Free-running Galois LFSR; seeded non-zero so it never locks up.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= IDX_W'(1);
        else        lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? MASK : '0);
    end

    // Lowest-index invalid slot finder.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Final victim selection.
    always_comb begin
        if (any_free)      victim_idx = free_idx;
        else if (pol_rand) victim_idx = lfsr_q;
        else               victim_idx = rr_q;
    end

endmodule

// File: rtl/utlb_top.sv
`timescale 1ns/1ps
// utlb_top: fully associative micro-TLB with ASID, global and security
// tags, single-cycle combinational lookup with permission check,
// refill with selectable replacement, and two kinds of invalidation.
// Assumes: refill and invalidation may coincide; the refill survives.
module utlb_top
    import utlb_pkg::*;
#(
    parameter int N      = 32,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_ns,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_abort,
    input  logic              rf_en,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic              rf_ns,
    input  logic              rf_global,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [2:0]        rf_perm,
    input  logic              pol_rand,
    input  logic              inv_all,
    input  logic              inv_asid_en,
    input  logic [ASID_W-1:0] inv_asid
);

    localparam int IDX_W = $clog2(N);

    logic [N-1:0]        match_vec;
    logic [N-1:0]        valid_vec;
    logic [N*PFN_W-1:0]  pfn_flat;
    logic [N*PERM_W-1:0] perm_flat;
    logic [IDX_W-1:0]    victim_idx;
    logic                hit;
    logic [PFN_W-1:0]    sel_pfn;
    logic [PERM_W-1:0]   sel_perm;
    logic                deny;

    utlb_tag_array #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (lk_vpn),
        .lk_asid    (lk_asid),
        .lk_ns      (lk_ns),
        .match_vec  (match_vec),
        .valid_vec  (valid_vec),
        .pfn_flat   (pfn_flat),
        .perm_flat  (perm_flat),
        .wr_en      (rf_en),
        .wr_idx     (victim_idx),
        .wr_vpn     (rf_vpn),
        .wr_asid    (rf_asid),
        .wr_ns      (rf_ns),
        .wr_glob    (rf_global),
        .wr_pfn     (rf_pfn),
        .wr_perm    (rf_perm),
        .inv_all    (inv_all),
        .inv_asid_en(inv_asid_en),
        .inv_asid   (inv_asid)
    );

    utlb_hit_select #(.N(N), .PFN_W(PFN_W)) u_select (
        .match_vec(match_vec),
        .pfn_flat (pfn_flat),
        .perm_flat(perm_flat),
        .hit      (hit),
        .sel_pfn  (sel_pfn),
        .sel_perm (sel_perm)
    );

    utlb_perm_check u_perm (
        .acc (lk_acc),
        .perm(sel_perm),
        .deny(deny)
    );

    utlb_victim #(.N(N)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .rf_en     (rf_en),
        .pol_rand  (pol_rand),
        .victim_idx(victim_idx)
    );

    // Output gating: frame and abort only qualify with a hit.
    assign lk_hit   = hit;
    assign lk_pfn   = hit ? sel_pfn : '0;
    assign lk_abort = hit && deny;

endmodule

// File: rtl/utlb_checker.sv
`timescale 1ns/1ps
// utlb_checker: temporal properties of the micro-TLB, bound to utlb_top.
module utlb_checker #(
    parameter int N     = 32,
    parameter int PFN_W = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_hit,
    input logic                 lk_abort,
    input logic [PFN_W-1:0]     lk_pfn,
    input logic                 rf_en,
    input logic                 inv_all,
    input logic [N-1:0]         valid_vec,
    input logic [$clog2(N)-1:0] victim_idx
);

    // R5: abort never appears without a hit.
    a_r5_abort_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_abort |-> lk_hit);

    // R4: a miss presents a zero frame number.
    a_r4_miss_zero_pfn: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pfn == '0));

    // R6: while a free slot exists, the chosen slot is a free one.
    a_r6_fill_prefers_free: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && !(&valid_vec)) |-> !valid_vec[victim_idx]);

    // R7 and R9: the refilled slot is valid after the edge, even under a flush.
    a_r7_refill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |=> valid_vec[$past(victim_idx)]);

    // R9: a flush without a refill leaves nothing valid.
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !rf_en) |=> (valid_vec == '0));

endmodule

bind utlb_top utlb_checker #(.N(N), .PFN_W(PFN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_hit    (lk_hit),
    .lk_abort  (lk_abort),
    .lk_pfn    (lk_pfn),
    .rf_en     (rf_en),
    .inv_all   (inv_all),
    .valid_vec (valid_vec),
    .victim_idx(victim_idx)
);

// File: tb/tb_utlb_top.sv
`timescale 1ns/1ps
module tb_utlb_top;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_ns = 1'b0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic        lk_abort;
    logic        rf_en = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic        rf_ns = 1'b0;
    logic        rf_global = 1'b0;
    logic [19:0] rf_pfn = '0;
    logic [2:0]  rf_perm = '0;
    logic        pol_rand = 1'b0;
    logic        inv_all = 1'b0;
    logic        inv_asid_en = 1'b0;
    logic [7:0]  inv_asid = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    utlb_top dut (.*);

    // Slot-by-slot model of the expected contents.
    logic        m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [7:0]  m_asid  [N];
    logic        m_ns    [N];
    logic        m_glob  [N];
    logic [19:0] m_pfn   [N];
    logic [2:0]  m_perm  [N];
    int          m_ptr = 0;

    function automatic int m_find(logic [19:0] v, logic [7:0] a, logic s);
        for (int k = 0; k < N; k++)
            if (m_valid[k] && m_vpn[k] == v && m_ns[k] == s && (m_glob[k] || m_asid[k] == a))
                return k;
        return -1;
    endfunction

    task automatic cmp(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic probe(logic [19:0] v, logic [7:0] a, logic s, logic [1:0] acc);
        @(negedge clk);
        lk_vpn = v; lk_asid = a; lk_ns = s; lk_acc = acc;
        #1;
    endtask

    task automatic chk(logic [19:0] v, logic [7:0] a, logic s, logic [1:0] acc, string rq);
        int e;
        logic eh, ea;
        logic [19:0] ep;
        e  = m_find(v, a, s);
        eh = (e >= 0);
        ep = eh ? m_pfn[e] : 20'h0;
        ea = eh && (acc == 2'b11 || !m_perm[e][acc]);
        probe(v, a, s, acc);
        cmp(rq, "hit", int'(lk_hit), int'(eh));
        cmp(rq, "pfn", int'(lk_pfn), int'(ep));
        cmp("R5", "abort", int'(lk_abort), int'(ea));
    endtask

    task automatic sweep(string rq);
        for (int k = 0; k < N; k++) begin
            if (m_valid[k]) begin
                for (int acc = 0; acc < 4; acc++)
                    chk(m_vpn[k], m_asid[k], m_ns[k], 2'(acc), rq);
                chk(m_vpn[k], m_asid[k] ^ 8'h80, m_ns[k], 2'b00, "R4");
                chk(m_vpn[k], m_asid[k], !m_ns[k], 2'b00, "R3");
            end
        end
    endtask

    // Refill drive; returns the model slot (-1 when the victim is random).
    task automatic refill(logic [19:0] v, logic [7:0] a, logic s, logic g,
                          logic [19:0] p, logic [2:0] pm, logic rnd, logic flush,
                          output int slot);
        slot = -1;
        if (flush)
            for (int k = 0; k < N; k++) m_valid[k] = 1'b0;
        for (int k = N - 1; k >= 0; k--) if (!m_valid[k]) slot = k;
        if (slot < 0 && !rnd) slot = m_ptr;
        m_ptr = (m_ptr + 1) % N;
        if (slot >= 0) begin
            m_valid[slot] = 1'b1; m_vpn[slot] = v; m_asid[slot] = a;
            m_ns[slot] = s; m_glob[slot] = g; m_pfn[slot] = p; m_perm[slot] = pm;
        end
        @(negedge clk);
        rf_en = 1'b1; rf_vpn = v; rf_asid = a; rf_ns = s; rf_global = g;
        rf_pfn = p; rf_perm = pm; pol_rand = rnd; inv_all = flush;
        @(negedge clk);
        rf_en = 1'b0; inv_all = 1'b0; pol_rand = 1'b0;
    endtask

    function automatic logic [19:0] pg_vpn(int i);  return 20'h01000 + 20'(i * 37); endfunction
    function automatic logic [7:0]  pg_asid(int i); return 8'h10 + 8'(i % 4);       endfunction
    function automatic logic        pg_ns(int i);   return 1'((i / 4) % 2);          endfunction
    function automatic logic        pg_glob(int i); return (i % 8) == 7;             endfunction
    function automatic logic [19:0] pg_pfn(int i);  return 20'hA0000 ^ 20'(i * 4099); endfunction
    function automatic logic [2:0]  pg_perm(int i); return 3'(i % 8);                endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int slot, gone, hits;
        for (int k = 0; k < N; k++) m_valid[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing hits after reset.
        for (int i = 0; i < 40; i++) chk(pg_vpn(i), pg_asid(i), pg_ns(i), 2'b00, "R1");

        // R6 and R2: fill every slot, each landing in the lowest free slot.
        for (int i = 0; i < N; i++) begin
            refill(pg_vpn(i), pg_asid(i), pg_ns(i), pg_glob(i), pg_pfn(i), pg_perm(i), 1'b0, 1'b0, slot);
            cmp("R6", "slot", slot, i);
            chk(pg_vpn(i), pg_asid(i), pg_ns(i), 2'b00, "R2");
        end
        sweep("R3");

        // R7: round-robin evicts slot 0, then slot 1.
        refill(20'hF0001, 8'h33, 1'b0, 1'b0, 20'h11111, 3'b111, 1'b0, 1'b0, slot);
        cmp("R7", "slot", slot, 0);
        chk(pg_vpn(0), pg_asid(0), pg_ns(0), 2'b00, "R7");
        refill(20'hF0002, 8'h33, 1'b1, 1'b1, 20'h22222, 3'b101, 1'b0, 1'b0, slot);
        cmp("R7", "slot", slot, 1);
        chk(pg_vpn(1), pg_asid(1), pg_ns(1), 2'b00, "R7");
        sweep("R7");

        // R8: a random victim replaces exactly one live page.
        refill(20'hF0003, 8'h44, 1'b0, 1'b0, 20'h33333, 3'b011, 1'b1, 1'b0, slot);
        gone = -1; hits = 0;
        for (int k = 0; k < N; k++) begin
            probe(m_vpn[k], m_asid[k], m_ns[k], 2'b00);
            if (lk_hit && lk_pfn == m_pfn[k]) hits++;
            else gone = k;
        end
        cmp("R8", "survivors", hits, N - 1);
        if (gone >= 0) begin
            m_vpn[gone] = 20'hF0003; m_asid[gone] = 8'h44; m_ns[gone] = 1'b0;
            m_glob[gone] = 1'b0; m_pfn[gone] = 20'h33333; m_perm[gone] = 3'b011;
        end
        chk(20'hF0003, 8'h44, 1'b0, 2'b01, "R8");

        // R10: flush one ASID; globals and other ASIDs remain.
        @(negedge clk);
        inv_asid_en = 1'b1; inv_asid = 8'h12;
        for (int k = 0; k < N; k++)
            if (m_valid[k] && !m_glob[k] && m_asid[k] == 8'h12) m_valid[k] = 1'b0;
        @(negedge clk);
        inv_asid_en = 1'b0;
        for (int i = 0; i < N; i++) chk(pg_vpn(i), pg_asid(i), pg_ns(i), 2'b10, "R10");
        sweep("R10");

        // R6: the next refill reuses a freed slot and evicts no live page.
        refill(20'hF0004, 8'h55, 1'b1, 1'b0, 20'h44444, 3'b110, 1'b0, 1'b0, slot);
        cmp("R6", "free slot", int'(slot >= 0 && pg_asid(slot) == 8'h12 && !pg_glob(slot)), 1);
        sweep("R6");

        // R9: flush with a simultaneous refill keeps only the refill.
        refill(20'h0BEEF, 8'h01, 1'b0, 1'b0, 20'h55555, 3'b001, 1'b0, 1'b1, slot);
        cmp("R9", "slot", slot, 0);
        for (int i = 0; i < N; i++) chk(pg_vpn(i), pg_asid(i), pg_ns(i), 2'b00, "R9");
        chk(20'h0BEEF, 8'h01, 1'b0, 2'b00, "R9");

        // R11: duplicate page; the lower slot answers.
        refill(20'h0CAFE, 8'h02, 1'b0, 1'b0, 20'h66666, 3'b001, 1'b0, 1'b0, slot);
        refill(20'h0CAFE, 8'h02, 1'b0, 1'b1, 20'h77777, 3'b110, 1'b0, 1'b0, slot);
        for (int acc = 0; acc < 4; acc++) chk(20'h0CAFE, 8'h02, 1'b0, 2'(acc), "R11");
        chk(20'h0CAFE, 8'h09, 1'b0, 2'b01, "R11");

        // R9: a plain flush empties everything.
        @(negedge clk);
        inv_all = 1'b1;
        for (int k = 0; k < N; k++) m_valid[k] = 1'b0;
        @(negedge clk);
        inv_all = 1'b0;
        chk(20'h0BEEF, 8'h01, 1'b0, 2'b00, "R9");
        chk(20'h0CAFE, 8'h02, 1'b0, 2'b00, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule